// File: doc/BRIEF.md
# Sequential Table-Free AES Byte Substitution

This unit returns the forward or the inverse AES substitution of a single byte without holding any lookup table. All of its arithmetic runs on one bit-serial multiply-accumulate engine. The engine consumes one multiplier bit per clock and always runs eight steps per product. The field inversion is built from fourteen products reduced by the AES field polynomial X^8+X^4+X^3+X+1. The affine step is one further product, reduced by X^8+1, whose accumulator starts at the affine constant. Because X^8+1 reduction turns the left shift into a rotation, the circulant affine matrix becomes a ring product on the same hardware.

A caller presents a byte and a direction and raises the start strobe. The unit raises busy, runs fifteen products (120 cycles), then pulses done with the result on the output. The result stays on the output until the next request completes. The sequence of operations never depends on the data. Every request therefore costs the same number of cycles, which keeps the timing independent of secret values.

Top module: `sbox_seq`

## Requirements
- R1: With `fwd_i`=1 at the accepted start, `dout_o` at the done pulse equals the forward AES S-box value of `din_i`, for every one of the 256 bytes.
- R2: With `fwd_i`=0 at the accepted start, `dout_o` at the done pulse equals the inverse AES S-box value of `din_i`, for every one of the 256 bytes.
- R3: Byte 0x00 is treated as inverting to 0x00. Forward 0x00 gives 0x63, inverse 0x63 gives 0x00, and inverse 0x00 gives 0x52.
- R4: `done_o` is high exactly 120 clock edges after the edge that accepts a start, for every byte and for both directions.
- R5: `busy_o` is high from the cycle after an accepted start until the done pulse, and low while `done_o` is high. `done_o` is high for one cycle only.
- R6: A start raised while `busy_o` is high is ignored. The running request still finishes at its original time with its original result.
- R7: `dout_o` changes only in the cycle where `done_o` rises, and then holds its value while no request completes.
- R8: While `rst_n` is low, and right after it is released, `busy_o`, `done_o` and `dout_o` are all 0.
- R9: `fwd_i` and `din_i` are sampled only at the accepted start. Changing either of them during a request does not alter its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, accepted when `busy_o` is low |
| fwd_i | input | 1 | 1 selects the forward substitution, 0 selects the inverse |
| din_i | input | 8 | Byte to substitute |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| dout_o | output | 8 | Substituted byte, held until the next completion |

## Verification
The bench sweeps all 256 bytes in both directions and compares them against a model built by exhaustive search for inverses and a rotate-and-XOR affine map. A wrong reduction polynomial or a wrong preload constant would corrupt most of this sweep. The zero byte is checked on its own: an inversion that mishandles zero would return something other than 0x63 forward and 0x52 inverse. The cycle count is measured for every request, so a multiply loop that stopped early on a zero multiplier would show up as a data-dependent latency. A directed run pulses start and flips the direction and data in the middle of a request. A unit that reloaded or resampled its inputs would then return the wrong byte or finish late.

// File: rtl/sbox_seq_pkg.sv
package sbox_seq_pkg;

  localparam int BYTE_W     = 8;
  localparam int SQ_ROUNDS  = 7;                    // multiply+square pairs for x^254
  localparam int OP_COUNT   = 2 * SQ_ROUNDS + 1;    // inversion products plus affine product
  localparam int OP_CW      = $clog2(OP_COUNT);
  localparam int BIT_CW     = $clog2(BYTE_W);
  localparam int MAC_LAT    = OP_COUNT * BYTE_W;    // cycles from accept to done

  localparam logic [BYTE_W:0] FIELD_POLY = 9'h11B;  // X^8+X^4+X^3+X+1
  localparam logic [BYTE_W:0] RING_POLY  = 9'h101;  // X^8+1, makes the shift a rotation

  typedef struct packed {
    logic [BYTE_W-1:0] mplier;   // shifted right, bit 0 gates the accumulate
    logic [BYTE_W-1:0] mcand;    // shifted left, reduced by the polynomial
    logic [BYTE_W-1:0] acc;      // running sum
  } mac_state_t;

  typedef struct packed {
    mac_state_t        st;
    logic [BYTE_W:0]   poly;
  } mac_op_t;

  // One step of the bit-serial multiply-accumulate.
  function automatic mac_state_t mac_step(mac_state_t s, logic [BYTE_W:0] poly);
    mac_state_t      n;
    logic [BYTE_W:0] sh;
    n.acc    = s.mplier[0] ? (s.acc ^ s.mcand) : s.acc;
    n.mplier = s.mplier >> 1;
    sh       = {s.mcand, 1'b0};
    if (sh[BYTE_W]) sh = sh ^ poly;
    n.mcand  = sh[BYTE_W-1:0];
    return n;
  endfunction

  // Operands of product number idx. prev is the previous product, base the value to invert.
  function automatic mac_op_t op_plan(
    logic              fwd,
    int unsigned       idx,
    logic [BYTE_W-1:0] prev,
    logic [BYTE_W-1:0] base,
    logic [BYTE_W-1:0] fwd_mat,
    logic [BYTE_W-1:0] fwd_add,
    logic [BYTE_W-1:0] inv_mat,
    logic [BYTE_W-1:0] inv_add
  );
    mac_op_t     p;
    int unsigned j;
    p = '0;
    j = fwd ? idx : idx - 1;
    if (fwd && idx == OP_COUNT - 1) begin
      p.st.mplier = prev;
      p.st.mcand  = fwd_mat;
      p.st.acc    = fwd_add;
      p.poly      = RING_POLY;
    end else if (!fwd && idx == 0) begin
      p.st.mplier = base;
      p.st.mcand  = inv_mat;
      p.st.acc    = inv_add;
      p.poly      = RING_POLY;
    end else begin
      p.poly   = FIELD_POLY;
      p.st.acc = '0;
      if (j[0] == 1'b0) begin
        p.st.mplier = (j == 0) ? BYTE_W'(1) : prev;   // running power times the base
        p.st.mcand  = base;
      end else begin
        p.st.mplier = prev;                            // squaring
        p.st.mcand  = prev;
      end
    end
    return p;
  endfunction

endpackage

// File: rtl/sbox_seq_mac.sv
module sbox_seq_mac
  import sbox_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  mac_op_t           op_i,
  input  logic              step_i,
  output logic [BYTE_W-1:0] prod_o
);

  mac_state_t      st_q;
  mac_state_t      st_nx;
  logic [BYTE_W:0] poly_q;

  always_comb st_nx = mac_step(st_q, poly_q);

  // The result of the step now in flight; on the last step it is the finished product.
  assign prod_o = st_nx.acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      poly_q <= '0;
    end else if (load_i) begin
      st_q   <= op_i.st;
      poly_q <= op_i.poly;
    end else if (step_i) begin
      st_q   <= st_nx;
    end
  end

endmodule

// File: rtl/sbox_seq_ctrl.sv
module sbox_seq_ctrl
  import sbox_seq_pkg::*;
#(
  parameter logic [BYTE_W-1:0] FWD_MAT = 8'h1F,
  parameter logic [BYTE_W-1:0] FWD_ADD = 8'h63,
  parameter logic [BYTE_W-1:0] INV_MAT = 8'h4A,
  parameter logic [BYTE_W-1:0] INV_ADD = 8'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              fwd_i,
  input  logic [BYTE_W-1:0] din_i,
  input  logic [BYTE_W-1:0] prod_i,
  output logic              busy_o,
  output logic              load_o,
  output mac_op_t           op_o,
  output logic              step_o,
  output logic              seg_end_o,
  output logic              finish_o
);

  logic              busy_q;
  logic              fwd_q;
  logic [BYTE_W-1:0] base_q;
  logic [OP_CW-1:0]  op_q;
  logic [BIT_CW-1:0] bit_q;
  logic [OP_CW-1:0]  op_nx;
  logic              accept;
  logic              bit_last;
  logic              op_last;
  logic              base_from_prod;
  logic [BYTE_W-1:0] base_eff;

  assign accept         = start_i & ~busy_q;
  assign bit_last       = (bit_q == BIT_CW'(BYTE_W - 1));
  assign op_last        = (op_q == OP_CW'(OP_COUNT - 1));
  assign op_nx          = op_q + OP_CW'(1);
  assign base_from_prod = ~fwd_q & (op_q == '0);   // inverse: affine output is the value to invert
  assign base_eff       = base_from_prod ? prod_i : base_q;

  assign seg_end_o = busy_q & bit_last & ~op_last;
  assign finish_o  = busy_q & bit_last & op_last;
  assign load_o    = accept | seg_end_o;
  assign step_o    = busy_q;
  assign busy_o    = busy_q;

  always_comb begin
    if (accept)
      op_o = op_plan(fwd_i, 0, '0, din_i, FWD_MAT, FWD_ADD, INV_MAT, INV_ADD);
    else
      op_o = op_plan(fwd_q, int'(op_nx), prod_i, base_eff, FWD_MAT, FWD_ADD, INV_MAT, INV_ADD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fwd_q  <= 1'b0;
      base_q <= '0;
      op_q   <= '0;
      bit_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      fwd_q  <= fwd_i;
      base_q <= din_i;
      op_q   <= '0;
      bit_q  <= '0;
    end else if (busy_q) begin
      bit_q <= bit_q + BIT_CW'(1);
      if (bit_last) begin
        if (op_last) begin
          busy_q <= 1'b0;
        end else begin
          op_q <= op_nx;
          if (base_from_prod) base_q <= prod_i;
        end
      end
    end
  end

endmodule

// File: rtl/sbox_seq.sv
module sbox_seq
  import sbox_seq_pkg::*;
#(
  parameter logic [BYTE_W-1:0] FWD_MAT = 8'h1F,
  parameter logic [BYTE_W-1:0] FWD_ADD = 8'h63,
  parameter logic [BYTE_W-1:0] INV_MAT = 8'h4A,
  parameter logic [BYTE_W-1:0] INV_ADD = 8'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              fwd_i,
  input  logic [BYTE_W-1:0] din_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] dout_o
);

  mac_op_t           load_op_w;
  logic              load_w;
  logic              step_w;
  logic              seg_end_w;
  logic              finish_w;
  logic [BYTE_W-1:0] prod_w;
  logic [BYTE_W-1:0] result_q;
  logic              done_q;

  sbox_seq_ctrl #(
    .FWD_MAT (FWD_MAT),
    .FWD_ADD (FWD_ADD),
    .INV_MAT (INV_MAT),
    .INV_ADD (INV_ADD)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .fwd_i     (fwd_i),
    .din_i     (din_i),
    .prod_i    (prod_w),
    .busy_o    (busy_o),
    .load_o    (load_w),
    .op_o      (load_op_w),
    .step_o    (step_w),
    .seg_end_o (seg_end_w),
    .finish_o  (finish_w)
  );

  sbox_seq_mac u_mac (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_w),
    .op_i   (load_op_w),
    .step_i (step_w),
    .prod_o (prod_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= finish_w;
      if (finish_w) result_q <= prod_w;
    end
  end

  assign done_o = done_q;
  assign dout_o = result_q;

endmodule

// File: rtl/sbox_seq_chk.sv
module sbox_seq_chk
  import sbox_seq_pkg::*;
#(
  parameter int LAT = MAC_LAT
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [BYTE_W-1:0] dout_o,
  input logic              finish_w,
  input logic              seg_end_w
);

  logic [15:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lat_cnt <= '0;
    else if (start_i && !busy_o) lat_cnt <= '0;
    else if (busy_o)           lat_cnt <= lat_cnt + 16'd1;
  end

  a_r5_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r5_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lat_cnt == 16'(LAT)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(dout_o));

  a_r7_finish_done: assert property (@(posedge clk) disable iff (!rst_n)
    finish_w |=> done_o);

  a_r4_seg_busy: assert property (@(posedge clk) disable iff (!rst_n)
    seg_end_w |=> busy_o);

endmodule

bind sbox_seq sbox_seq_chk #(.LAT(sbox_seq_pkg::MAC_LAT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .dout_o    (dout_o),
  .finish_w  (finish_w),
  .seg_end_w (seg_end_w)
);

// File: tb/tb_sbox_seq.sv
module tb_sbox_seq;

  localparam int CLK_PERIOD = 10;
  localparam int EXP_LAT    = 120;
  localparam int WD_CYCLES  = 190000;

  // {forward select, input byte, expected byte}
  localparam logic [16:0] VEC [8] = '{
    {1'b1, 8'h00, 8'h63},
    {1'b1, 8'h01, 8'h7C},
    {1'b1, 8'h53, 8'hED},
    {1'b1, 8'hFF, 8'h16},
    {1'b0, 8'h63, 8'h00},
    {1'b0, 8'h00, 8'h52},
    {1'b0, 8'hED, 8'h53},
    {1'b0, 8'h16, 8'hFF}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       fwd_i = 1'b0;
  logic [7:0] din_i = 8'h00;
  logic       busy_o;
  logic       done_o;
  logic [7:0] dout_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] ref_fwd [256];
  logic [7:0] ref_inv [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  sbox_seq dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .fwd_i   (fwd_i),
    .din_i   (din_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .dout_o  (dout_o)
  );

  function automatic logic [7:0] gf_mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ aa;
      aa = aa[7] ? ((aa << 1) ^ 8'h1B) : (aa << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl(logic [7:0] v, int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic f, input logic [7:0] d,
                        output logic [7:0] r, output int lat);
    @(negedge clk);
    start_i = 1'b1; fwd_i = f; din_i = d;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    r = dout_o;
  endtask

  initial begin
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 8'h00;
      for (int y = 1; y < 256; y++)
        if (x != 0 && gf_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      ref_fwd[x] = inv ^ rotl(inv, 1) ^ rotl(inv, 2) ^ rotl(inv, 3) ^ rotl(inv, 4) ^ 8'h63;
    end
    for (int x = 0; x < 256; x++) ref_inv[ref_fwd[x]] = 8'(x);
  end

  initial begin
    logic [7:0] r;
    int         lat;
    logic [7:0] held;

    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8 busy in reset", busy_o, 0);
    check("R8 done in reset", done_o, 0);
    check("R8 dout in reset", dout_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 busy after reset", busy_o, 0);
    check("R8 dout after reset", dout_o, 0);

    // known vectors, including the zero cases of R3
    for (int i = 0; i < 8; i++) begin
      run_op(VEC[i][16], VEC[i][15:8], r, lat);
      check("R3 vector table", r, VEC[i][7:0]);
      check("R4 latency vector", lat, EXP_LAT);
    end

    // R5: busy and done shape
    @(negedge clk);
    start_i = 1'b1; fwd_i = 1'b1; din_i = 8'h10;
    @(negedge clk);
    start_i = 1'b0;
    check("R5 busy after accept", busy_o, 1);
    check("R5 no early done", done_o, 0);
    repeat (EXP_LAT - 1) @(negedge clk);
    check("R5 busy before done", busy_o, 1);
    @(negedge clk);
    check("R5 done pulse", done_o, 1);
    check("R5 busy low at done", busy_o, 0);
    check("R1 forward 10", dout_o, 8'hCA);
    held = dout_o;
    @(negedge clk);
    check("R5 done single cycle", done_o, 0);

    // R7: result held while idle
    repeat (20) @(negedge clk);
    check("R7 result held", dout_o, held);
    check("R7 no spurious done", done_o, 0);

    // R6 and R9: start pulse plus direction and data change during a request
    @(negedge clk);
    start_i = 1'b1; fwd_i = 1'b1; din_i = 8'h53;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 1000) begin
      if (lat == 10) begin start_i = 1'b1; fwd_i = 1'b0; din_i = 8'h00; end
      if (lat == 11) start_i = 1'b0;
      if (lat == 50) check("R7 dout stable mid run", dout_o, held);
      @(negedge clk);
      lat++;
    end
    check("R6 ignored start latency", lat, EXP_LAT);
    check("R9 sampled inputs result", dout_o, 8'hED);
    @(negedge clk);
    check("R6 no second request", busy_o, 0);

    // R1, R2, R4: full sweep in both directions
    for (int x = 0; x < 256; x++) begin
      run_op(1'b1, 8'(x), r, lat);
      check("R1 forward sweep", r, ref_fwd[x]);
      check("R4 forward latency", lat, EXP_LAT);
    end
    for (int x = 0; x < 256; x++) begin
      run_op(1'b0, 8'(x), r, lat);
      check("R2 inverse sweep", r, ref_inv[x]);
      check("R4 inverse latency", lat, EXP_LAT);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog actual=%0d expected=finish", WD_CYCLES);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule